// File: doc/BRIEF.md
# Four-channel prescaled PWM controller

This block is a memory-mapped pulse-width modulator with four independent output channels. Each channel holds a 16-bit period count, a 16-bit duty count, a 6-bit clock divider, an enable bit and a polarity bit. The counts, divider and polarity are programmed over a small word-addressed register port. Setting a channel's enable bit starts a fresh waveform on its output pin. The waveform's period lasts (divider+1) times the period count in input clocks, and it is active for (divider+1) times the duty count at the start of every period.

Settings are captured when a channel is enabled, so software may rewrite a running channel's registers freely. The new values apply after the enable bit is cleared and set again. A disabled channel stops within one clock and rests at the idle level chosen by its polarity bit, which is well inside the minimum 400 ns gap software must leave between clearing and setting an enable bit.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset every register reads zero, every channel is stopped, and since polarity 0 means inverted, every output rests high.
- R2: The control word at byte offset 0x00 holds enable of channel n in bit n, polarity in bit 8+n and a drive-type bit in bit 15+n; all other control bits read 0. Period and duty registers (offsets 0x04+8n and 0x08+8n) keep their low 16 bits. The divider word at 0x24 keeps its low 24 bits. Unused bits read 0.
- R3: Any other byte offset, including a misaligned one, reads zero, and a write to it changes no register.
- R4: Channel n's 6-bit divider is the field starting at bit (3-n)*6 of the divider word, so channel 0 uses bits 23:18 and channel 3 uses bits 5:0.
- R5: With divider p, period count PC and duty count DC, a running channel repeats a period of (p+1)*PC clocks. The output is active for the first (p+1)*DC clocks of each period, beginning with the first clock after the enable edge.
- R6: A polarity bit of 1 makes the active level high; a polarity bit of 0 makes the active level low.
- R7: One clock after a channel's enable bit reads 0, the channel is stopped. A stopped channel's output sits at the inactive level of its current polarity bit and follows that bit at once.
- R8: A channel captures its period, duty, divider and polarity at the clock edge after its enable bit goes from 0 to 1. Later writes to those registers leave the running waveform unchanged until the next enable.
- R9: A duty count of 0 keeps the output inactive. A duty count greater than or equal to the period count keeps it active for the whole period.
- R10: A period count of 0 or 1 is treated as 2.
- R11: The four channels run independently; settings and enable changes on one channel never affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read request, zero otherwise |
| pwm_out | output | 4 | One waveform output per channel, bit n for channel n |

## Verification
A write takes effect at the clock edge that ends its bus cycle. Read data is combinational, so the bench checks it shortly after driving a read, before the next edge. An enable change is acted on at the next edge after the control register holds it. The waveform's first active cycle therefore follows two edges after the enabling write, and a stop shows one edge after the clearing write. The bench's reference model steps at every rising edge with exactly that ordering: it advances each channel from the register values held before the edge, then applies that edge's write. The model's predicted outputs are compared with pwm_out at every falling edge.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int NCH       = 4;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 6;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int EN_LSB    = 0;
  localparam int POL_LSB   = 8;
  localparam int DRV_LSB   = 15;
  localparam int PER_BASE  = 4;
  localparam int DUTY_BASE = 8;
  localparam int STRIDE    = 8;
  localparam int PRE_OFF   = 36;
  localparam int MIN_PER   = 2;
  localparam int PREW_W    = NCH * PRE_W;

  function automatic logic [ADDR_W-1:0] per_addr(input int n);
    return ADDR_W'(PER_BASE + STRIDE * n);
  endfunction

  function automatic logic [ADDR_W-1:0] duty_addr(input int n);
    return ADDR_W'(DUTY_BASE + STRIDE * n);
  endfunction

  // Fields are packed highest channel lowest: channel n sits at (NCH-1-n)*PRE_W.
  function automatic logic [PRE_W-1:0] pre_field(input logic [PREW_W-1:0] w, input int n);
    return w[(NCH-1-n)*PRE_W +: PRE_W];
  endfunction

  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] pc);
    return (pc < CNT_W'(MIN_PER)) ? CNT_W'(MIN_PER) : pc;
  endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
  import pwm4_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NCH-1:0]             en,
  output logic [NCH-1:0]             pol,
  output logic [NCH-1:0][CNT_W-1:0]  period,
  output logic [NCH-1:0][CNT_W-1:0]  duty,
  output logic [PREW_W-1:0]          pre_word
);
  logic [NCH-1:0]    drv;
  logic              wr_hit;
  logic [DATA_W-1:0] rd_mux;

  assign wr_hit = bus_valid && bus_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      pol      <= '0;
      drv      <= '0;
      period   <= '0;
      duty     <= '0;
      pre_word <= '0;
    end else if (wr_hit) begin
      if (bus_addr == '0) begin
        en  <= bus_wdata[EN_LSB  +: NCH];
        pol <= bus_wdata[POL_LSB +: NCH];
        drv <= bus_wdata[DRV_LSB +: NCH];
      end
      if (bus_addr == ADDR_W'(PRE_OFF))
        pre_word <= bus_wdata[PREW_W-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == per_addr(n))  period[n] <= bus_wdata[CNT_W-1:0];
        if (bus_addr == duty_addr(n)) duty[n]   <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == '0) begin
      rd_mux[EN_LSB  +: NCH] = en;
      rd_mux[POL_LSB +: NCH] = pol;
      rd_mux[DRV_LSB +: NCH] = drv;
    end
    if (bus_addr == ADDR_W'(PRE_OFF))
      rd_mux = DATA_W'(pre_word);
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == per_addr(n))  rd_mux = DATA_W'(period[n]);
      if (bus_addr == duty_addr(n)) rd_mux = DATA_W'(duty[n]);
    end
  end

  assign bus_rdata = (bus_valid && !bus_write) ? rd_mux : '0;
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
  import pwm4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pol,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic [PRE_W-1:0] pre_in,
  output logic             run,
  output logic             start,
  output logic [CNT_W-1:0] per_cnt,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [CNT_W-1:0] per_lim,
  output logic [PRE_W-1:0] pre_lim,
  output logic             wave
);
  logic [CNT_W-1:0] duty_lat;
  logic             pol_lat;
  logic             pre_wrap;
  logic             per_wrap;
  logic             active;
  logic             pol_use;

  assign start    = en && !run;
  assign pre_wrap = (pre_cnt == pre_lim);
  assign per_wrap = (per_cnt == per_lim - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      per_cnt  <= '0;
      pre_cnt  <= '0;
      per_lim  <= CNT_W'(MIN_PER);
      pre_lim  <= '0;
      duty_lat <= '0;
      pol_lat  <= 1'b0;
    end else if (start) begin
      run      <= 1'b1;
      per_cnt  <= '0;
      pre_cnt  <= '0;
      per_lim  <= eff_period(period_in);
      pre_lim  <= pre_in;
      duty_lat <= duty_in;
      pol_lat  <= pol;
    end else if (!en) begin
      run     <= 1'b0;
      per_cnt <= '0;
      pre_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      per_cnt <= per_wrap ? '0 : per_cnt + CNT_W'(1);
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end

  assign active  = run && (per_cnt < duty_lat);
  assign pol_use = run ? pol_lat : pol;
  assign wave    = pol_use ? active : !active;
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
  import pwm4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        pwm_out
);
  logic [NCH-1:0]            ctrl_en;
  logic [NCH-1:0]            ctrl_pol;
  logic [NCH-1:0][CNT_W-1:0] reg_period;
  logic [NCH-1:0][CNT_W-1:0] reg_duty;
  logic [PREW_W-1:0]         reg_pre;
  logic [NCH-1:0]            ch_run;
  logic [NCH-1:0]            ch_start;
  logic [NCH-1:0][CNT_W-1:0] ch_per_cnt;
  logic [NCH-1:0][CNT_W-1:0] ch_per_lim;
  logic [NCH-1:0][PRE_W-1:0] ch_pre_cnt;
  logic [NCH-1:0][PRE_W-1:0] ch_pre_lim;

  pwm4_regs regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en(ctrl_en), .pol(ctrl_pol),
    .period(reg_period), .duty(reg_duty), .pre_word(reg_pre)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm4_chan chan_i (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_en[c]), .pol(ctrl_pol[c]),
      .period_in(reg_period[c]), .duty_in(reg_duty[c]),
      .pre_in(pre_field(reg_pre, c)),
      .run(ch_run[c]), .start(ch_start[c]),
      .per_cnt(ch_per_cnt[c]), .pre_cnt(ch_pre_cnt[c]),
      .per_lim(ch_per_lim[c]), .pre_lim(ch_pre_lim[c]),
      .wave(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm4_ctrl_chk.sv
module pwm4_ctrl_chk
  import pwm4_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            en,
  input logic [NCH-1:0]            pol,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0]            start,
  input logic [NCH-1:0]            out,
  input logic [NCH-1:0][CNT_W-1:0] per_cnt,
  input logic [NCH-1:0][CNT_W-1:0] per_lim,
  input logic [NCH-1:0][PRE_W-1:0] pre_cnt,
  input logic [NCH-1:0][PRE_W-1:0] pre_lim
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] |=> !run[c]);
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |-> (out[c] == !pol[c]));
    assert_fresh_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start[c] |=> (run[c] && per_cnt[c] == '0 && pre_cnt[c] == '0));
    assert_hold_settings_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && en[c]) |=> ($stable(per_lim[c]) && $stable(pre_lim[c])));
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] |-> (per_cnt[c] < per_lim[c] && pre_cnt[c] <= pre_lim[c]));
    assert_min_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run[c] |-> (per_lim[c] >= CNT_W'(MIN_PER)));
  end
endmodule

bind pwm4_ctrl pwm4_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .en(ctrl_en), .pol(ctrl_pol), .run(ch_run), .start(ch_start),
  .out(pwm_out),
  .per_cnt(ch_per_cnt), .per_lim(ch_per_lim),
  .pre_cnt(ch_pre_cnt), .pre_lim(ch_pre_lim)
);

// File: tb/pwm4_ctrl_tb.sv
`timescale 1ns/1ps
module pwm4_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  pwm4_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // Behavioural reference model
  bit [31:0] m_ctrl;
  int        m_pc[4], m_dc[4];
  int        m_prew;
  bit        m_run[4];
  int        m_t[4], l_pc[4], l_dc[4], l_pre[4];
  bit        l_pol[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_prew = 0;
      for (int c = 0; c < 4; c++) begin
        m_pc[c] = 0; m_dc[c] = 0; m_run[c] = 0; m_t[c] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (!m_ctrl[c]) begin
          m_run[c] = 0; m_t[c] = 0;
        end else if (!m_run[c]) begin
          m_run[c] = 1; m_t[c] = 0;
          l_pc[c]  = (m_pc[c] < 2) ? 2 : m_pc[c];
          l_dc[c]  = m_dc[c];
          l_pre[c] = (m_prew >> ((3 - c) * 6)) & 63;
          l_pol[c] = m_ctrl[8 + c];
        end else begin
          m_t[c] = (m_t[c] + 1) % (l_pc[c] * (l_pre[c] + 1));
        end
      end
      if (bus_valid && bus_write) begin
        if (bus_addr == 6'h00) m_ctrl = bus_wdata & 32'h0007_8F0F;
        if (bus_addr == 6'h24) m_prew = int'(bus_wdata & 32'h00FF_FFFF);
        for (int c = 0; c < 4; c++) begin
          if (int'(bus_addr) == 4 + 8 * c) m_pc[c] = int'(bus_wdata & 32'hFFFF);
          if (int'(bus_addr) == 8 + 8 * c) m_dc[c] = int'(bus_wdata & 32'hFFFF);
        end
      end
    end
  end

  function automatic bit exp_out(int c);
    bit act, p;
    act = m_run[c] && (m_t[c] < l_dc[c] * (l_pre[c] + 1));
    p   = m_run[c] ? l_pol[c] : m_ctrl[8 + c];
    return p ? act : !act;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int c = 0; c < 4; c++) begin
        n_tests++;
        if (pwm_out[c] !== exp_out(c)) begin
          n_fail++;
          $display("FAIL %s ch%0d @%0t: pwm_out=%0b expected %0b",
                   tag, c, $time, pwm_out[c], exp_out(c));
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string rq);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    n_tests++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", rq, a, bus_rdata, e);
    end
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values; outputs idle high (polarity 0)
    tag = "R1";
    rd_chk(6'h00, 0, "R1");
    for (int c = 0; c < 4; c++) begin
      rd_chk(6'(4 + 8 * c), 0, "R1");
      rd_chk(6'(8 + 8 * c), 0, "R1");
    end
    rd_chk(6'h24, 0, "R1");
    idle(4);

    // R2: field masks
    tag = "R2";
    wr(6'h00, 32'hFFFF_FFFF);
    rd_chk(6'h00, 32'h0007_8F0F, "R2");
    idle(6);
    wr(6'h00, 32'h0);
    rd_chk(6'h00, 32'h0, "R2");
    wr(6'h04, 32'hABCD_1234);
    rd_chk(6'h04, 32'h0000_1234, "R2");
    wr(6'h20, 32'hFFFF_5A5A);
    rd_chk(6'h20, 32'h0000_5A5A, "R2");
    wr(6'h24, 32'hFFFF_FFFF);
    rd_chk(6'h24, 32'h00FF_FFFF, "R2");

    // R3: unmapped and misaligned offsets
    tag = "R3";
    wr(6'h28, 32'hDEAD_BEEF);
    wr(6'h3C, 32'h1234_5678);
    wr(6'h01, 32'h0000_000F);
    rd_chk(6'h28, 0, "R3");
    rd_chk(6'h3C, 0, "R3");
    rd_chk(6'h01, 0, "R3");
    rd_chk(6'h00, 0, "R3");
    rd_chk(6'h04, 32'h1234, "R3");
    rd_chk(6'h20, 32'h5A5A, "R3");
    rd_chk(6'h24, 32'h00FF_FFFF, "R3");

    // R4/R5/R6/R9/R11: mixed dividers, periods, duties, polarities
    tag = "R4/R5/R6/R9/R11";
    wr(6'h24, (32'd1 << 18) | (32'd0 << 12) | (32'd2 << 6) | 32'd3);
    wr(6'h04, 5); wr(6'h08, 2);
    wr(6'h0C, 4); wr(6'h10, 0);
    wr(6'h14, 3); wr(6'h18, 3);
    wr(6'h1C, 6); wr(6'h20, 1);
    wr(6'h00, 32'h0000_0B0F);
    idle(300);

    // R8: writes while running have no effect until re-enable
    tag = "R8";
    wr(6'h04, 7); wr(6'h08, 3);
    wr(6'h24, 0);
    idle(100);
    tag = "R7";
    wr(6'h00, 32'h0000_0B0E);
    idle(3);
    wr(6'h00, 32'h0000_0A0E);
    idle(5);
    tag = "R8";
    wr(6'h00, 32'h0000_0B0F);
    idle(100);

    // R10: period counts below 2
    tag = "R10";
    wr(6'h0C, 1); wr(6'h10, 1);
    wr(6'h00, 32'h0000_0B0D);
    wr(6'h00, 32'h0000_0B0F);
    idle(40);
    wr(6'h0C, 0);
    wr(6'h00, 32'h0000_0B0D);
    wr(6'h00, 32'h0000_0B0F);
    idle(40);

    // R7: stop all
    tag = "R7";
    wr(6'h00, 32'h0000_0B00);
    idle(10);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule